// File: doc/BRIEF.md
# Pattern Stimulus Record Compare Port

An eight-bit tester channel group that steps through a vector memory, one word per pattern clock cycle. Each word carries eight pattern bits and four per-cycle control bits: a high-impedance request, a compare enable, an end-of-sequence marker and a branch marker. A host loads the vector memory and a small set of configuration registers while the port is stopped. It then pulses a start input, and the port runs from a preset address until something stops it.

The port works in one of three modes. In stimulus mode, the pattern bits drive the device pins. In record mode, the pins are sampled into the pattern bits of the current word. In compare mode, the pins are checked against the stored byte under a static don't-care mask. A compare mismatch freezes the port and keeps the failing address, the expected byte and the actual byte for the host. The failures of several ports can then be ranked by address without moving any response data.

Top module: `pattern_port`

## Requirements
- R1: After reset the port is stopped: running_o=0, stop_cause_o=0, cmp_err_o=0, cur_addr_o=0, pin_oe_o=0 and pin_o=0. The mode, mask, preset and branch registers are all zero.
- R2: A start_i pulse while stopped loads the preset register into cur_addr_o and sets running_o at the next edge. Each later running cycle advances the address by one, wrapping at the top of the memory.
- R3: A word is {branch[11], end[10], cmp_en[9], hiz[8], pattern[7:0]}. In stimulus mode (mode 0), while running, pin_o shows pattern. pin_oe_o is 1 unless hiz is set or ext_hiz_i is high. When the port is not running in stimulus mode, pin_o=0 and pin_oe_o=0.
- R4: In record mode (mode 1), pin_oe_o stays 0. At the end of each running cycle, pin_i is written into bits [7:0] of the current word, and bits [11:8] are kept.
- R5: In compare mode (mode 2), a word with cmp_en set fails when (pin_i XOR pattern) AND NOT mask is non-zero, where a mask bit of 1 means don't care. A word with cmp_en clear is never checked.
- R6: On a failure the port stops with stop_cause_o=2 and cmp_err_o=1. fail_addr_o, fail_exp_o and fail_act_o hold the word address, the pattern and pin_i, and all of these stay unchanged until the next start, which clears them to zero.
- R7: A word with end set completes its cycle (including any record write) and then stops the port with stop_cause_o=1. cur_addr_o stays on that word.
- R8: A word with branch set and end clear makes the next address the branch register instead of address+1. End takes priority over branch.
- R9: abort_i high in a running cycle stops the port with stop_cause_o=3. It takes priority over a compare failure and suppresses that cycle's record write.
- R10: With host_reg_i=1, host_addr_i[1:0] selects mode(0), mask(1), preset(2) or branch(3). Memory and register writes are ignored while running. host_re_i returns the addressed word on host_rdata_o one cycle later.
- R11: start_i while running has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pattern clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_we_i | input | 1 | Host write strobe |
| host_re_i | input | 1 | Host memory read strobe |
| host_reg_i | input | 1 | 1 selects a register, 0 selects the memory |
| host_addr_i | input | ADDR_W | Memory address or register index |
| host_wdata_i | input | max(ADDR_W,12) | Host write data |
| host_rdata_o | output | 12 | Memory word read by the host |
| start_i | input | 1 | Preset the address and run |
| abort_i | input | 1 | Host abort |
| ext_hiz_i | input | 1 | External forced high impedance |
| pin_i | input | 8 | Sampled device pins |
| pin_o | output | 8 | Stimulus pattern |
| pin_oe_o | output | 1 | Output driver enable |
| running_o | output | 1 | Port running |
| cmp_err_o | output | 1 | Compare failure flag |
| stop_cause_o | output | 2 | 0 none, 1 end, 2 error, 3 abort |
| cur_addr_o | output | ADDR_W | Address of the current vector |
| fail_addr_o | output | ADDR_W | Address of the first failure |
| fail_exp_o | output | 8 | Expected byte at the failure |
| fail_act_o | output | 8 | Actual byte at the failure |

## Verification
The pin outputs and the output enable follow the current word and ext_hiz_i in the same cycle. Address steps, stops, stop causes and captured failure data appear one edge after the cycle that causes them, and a host read appears one edge after host_re_i. The bench drives every input on the falling edge and checks shortly after it. At that point the combinational outputs reflect the inputs just applied, while the registered ones reflect the preceding rising edge. A model of memory, address and stop state in the bench is advanced once per rising edge, so each expected value lines up with the edge that produces it.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int PAT_W  = 8;
  localparam int WORD_W = 12;

  typedef enum logic [1:0] {
    MODE_STIM = 2'd0,
    MODE_REC  = 2'd1,
    MODE_CMP  = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    STOP_NONE  = 2'd0,
    STOP_END   = 2'd1,
    STOP_ERR   = 2'd2,
    STOP_ABORT = 2'd3
  } stop_e;

  typedef struct packed {
    logic             br;
    logic             eos;
    logic             cmp;
    logic             hiz;
    logic [PAT_W-1:0] pat;
  } vword_t;
endpackage

// File: rtl/pport_cfg.sv
module pport_cfg import pport_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int CFG_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        idx_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic              run_i,
  output mode_e             mode_o,
  output logic [PAT_W-1:0]  mask_o,
  output logic [ADDR_W-1:0] preset_o,
  output logic [ADDR_W-1:0] brdest_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= MODE_STIM;
      mask_o   <= '0;
      preset_o <= '0;
      brdest_o <= '0;
    end else if (wr_i && !run_i) begin
      case (idx_i)
        2'd0: mode_o   <= mode_e'(wdata_i[1:0]);
        2'd1: mask_o   <= wdata_i[PAT_W-1:0];
        2'd2: preset_o <= wdata_i[ADDR_W-1:0];
        default: brdest_o <= wdata_i[ADDR_W-1:0];
      endcase
    end
  end

  a_r10_cfg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> ($stable(mode_o) && $stable(mask_o) && $stable(preset_o) && $stable(brdest_o)));
endmodule

// File: rtl/pport_mem.sv
module pport_mem import pport_pkg::*; #(
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  vword_t            host_wdata_i,
  input  logic              host_re_i,
  output vword_t            host_rdata_o,
  input  logic              rec_we_i,
  input  logic [ADDR_W-1:0] rec_addr_i,
  input  logic [PAT_W-1:0]  rec_pat_i,
  input  logic [ADDR_W-1:0] run_addr_i,
  output vword_t            run_word_o
);
  vword_t mem_q [DEPTH];

  // record and host writes are exclusive: one needs run, the other needs stop
  always_ff @(posedge clk_i) begin
    if (rec_we_i)       mem_q[rec_addr_i].pat <= rec_pat_i;
    else if (host_we_i) mem_q[host_addr_i]    <= host_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        host_rdata_o <= '0;
    else if (host_re_i) host_rdata_o <= mem_q[host_addr_i];
  end

  assign run_word_o = mem_q[run_addr_i];

  a_r10_one_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rec_we_i && host_we_i));
endmodule

// File: rtl/pport_seq.sv
module pport_seq import pport_pkg::*; #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              fail_i,
  input  logic              eos_i,
  input  logic              br_i,
  input  logic [ADDR_W-1:0] preset_i,
  input  logic [ADDR_W-1:0] brdest_i,
  output logic              run_o,
  output logic [ADDR_W-1:0] ptr_o,
  output stop_e             cause_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o   <= 1'b0;
      ptr_o   <= '0;
      cause_o <= STOP_NONE;
    end else if (!run_o) begin
      if (start_i) begin
        run_o   <= 1'b1;
        ptr_o   <= preset_i;
        cause_o <= STOP_NONE;
      end
    end else if (abort_i) begin
      run_o   <= 1'b0;
      cause_o <= STOP_ABORT;
    end else if (fail_i) begin
      run_o   <= 1'b0;
      cause_o <= STOP_ERR;
    end else if (eos_i) begin
      run_o   <= 1'b0;
      cause_o <= STOP_END;
    end else begin
      ptr_o <= br_i ? brdest_i : ptr_o + ADDR_W'(1);
    end
  end

  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && start_i) |=> (run_o && ptr_o == $past(preset_i) && cause_o == STOP_NONE));
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !abort_i && !fail_i && !eos_i && !br_i) |=> (run_o && ptr_o == $past(ptr_o) + ADDR_W'(1)));
  a_r8_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !abort_i && !fail_i && !eos_i && br_i) |=> (ptr_o == $past(brdest_i)));
  a_r7_end_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !abort_i && !fail_i && eos_i) |=> (!run_o && cause_o == STOP_END && $stable(ptr_o)));
  a_r9_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && abort_i) |=> (!run_o && cause_o == STOP_ABORT));
  a_r11_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && start_i && !abort_i && !fail_i && !eos_i) |=> run_o);
endmodule

// File: rtl/pport_cmp.sv
module pport_cmp import pport_pkg::*; #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              start_i,
  input  logic              abort_i,
  input  mode_e             mode_i,
  input  logic              cmp_en_i,
  input  logic [PAT_W-1:0]  exp_i,
  input  logic [PAT_W-1:0]  pin_i,
  input  logic [PAT_W-1:0]  mask_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              fail_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [PAT_W-1:0]  fail_exp_o,
  output logic [PAT_W-1:0]  fail_act_o
);
  logic [PAT_W-1:0] diff;

  assign diff   = (pin_i ^ exp_i) & ~mask_i;
  assign fail_o = run_i && (mode_i == MODE_CMP) && cmp_en_i && (|diff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o       <= 1'b0;
      fail_addr_o <= '0;
      fail_exp_o  <= '0;
      fail_act_o  <= '0;
    end else if (!run_i && start_i) begin
      err_o       <= 1'b0;
      fail_addr_o <= '0;
      fail_exp_o  <= '0;
      fail_act_o  <= '0;
    end else if (fail_o && !abort_i) begin
      err_o       <= 1'b1;
      fail_addr_o <= addr_i;
      fail_exp_o  <= exp_i;
      fail_act_o  <= pin_i;
    end
  end

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(start_i && !run_i)) |=>
      (err_o && $stable(fail_addr_o) && $stable(fail_exp_o) && $stable(fail_act_o)));
  a_r5_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !cmp_en_i) |=> (err_o == $past(err_o)));
  a_r9_abort_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && abort_i && !err_o) |=> !err_o);
endmodule

// File: rtl/pport_drv.sv
module pport_drv import pport_pkg::*; (
  input  logic             run_i,
  input  mode_e            mode_i,
  input  logic             hiz_i,
  input  logic             ext_hiz_i,
  input  logic [PAT_W-1:0] pat_i,
  output logic [PAT_W-1:0] pin_o,
  output logic             pin_oe_o
);
  logic stim;

  assign stim     = run_i && (mode_i == MODE_STIM);
  assign pin_o    = stim ? pat_i : '0;
  assign pin_oe_o = stim && !hiz_i && !ext_hiz_i;
endmodule

// File: rtl/pattern_port.sv
module pattern_port import pport_pkg::*; #(
  parameter int ADDR_W = 10,
  localparam int HOST_W = (ADDR_W > WORD_W) ? ADDR_W : WORD_W,
  localparam int CFG_W  = (ADDR_W > PAT_W) ? ADDR_W : PAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic              host_re_i,
  input  logic              host_reg_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [HOST_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] host_rdata_o,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              ext_hiz_i,
  input  logic [PAT_W-1:0]  pin_i,
  output logic [PAT_W-1:0]  pin_o,
  output logic              pin_oe_o,
  output logic              running_o,
  output logic              cmp_err_o,
  output logic [1:0]        stop_cause_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [PAT_W-1:0]  fail_exp_o,
  output logic [PAT_W-1:0]  fail_act_o
);
  mode_e             mode;
  logic [PAT_W-1:0]  mask;
  logic [ADDR_W-1:0] preset, brdest, ptr;
  vword_t            word, rdata;
  logic              run, fail, mem_we, rec_we;
  stop_e             cause;

  assign mem_we = host_we_i && !host_reg_i && !run;
  assign rec_we = run && (mode == MODE_REC) && !abort_i;

  pport_cfg #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_cfg (
    .clk_i, .rst_ni,
    .wr_i     (host_we_i && host_reg_i),
    .idx_i    (host_addr_i[1:0]),
    .wdata_i  (host_wdata_i[CFG_W-1:0]),
    .run_i    (run),
    .mode_o   (mode),
    .mask_o   (mask),
    .preset_o (preset),
    .brdest_o (brdest)
  );

  pport_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i, .rst_ni,
    .host_we_i    (mem_we),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (vword_t'(host_wdata_i[WORD_W-1:0])),
    .host_re_i    (host_re_i),
    .host_rdata_o (rdata),
    .rec_we_i     (rec_we),
    .rec_addr_i   (ptr),
    .rec_pat_i    (pin_i),
    .run_addr_i   (ptr),
    .run_word_o   (word)
  );

  pport_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i  (start_i),
    .abort_i  (abort_i),
    .fail_i   (fail),
    .eos_i    (word.eos),
    .br_i     (word.br),
    .preset_i (preset),
    .brdest_i (brdest),
    .run_o    (run),
    .ptr_o    (ptr),
    .cause_o  (cause)
  );

  pport_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .clk_i, .rst_ni,
    .run_i       (run),
    .start_i     (start_i),
    .abort_i     (abort_i),
    .mode_i      (mode),
    .cmp_en_i    (word.cmp),
    .exp_i       (word.pat),
    .pin_i       (pin_i),
    .mask_i      (mask),
    .addr_i      (ptr),
    .fail_o      (fail),
    .err_o       (cmp_err_o),
    .fail_addr_o (fail_addr_o),
    .fail_exp_o  (fail_exp_o),
    .fail_act_o  (fail_act_o)
  );

  pport_drv u_drv (
    .run_i     (run),
    .mode_i    (mode),
    .hiz_i     (word.hiz),
    .ext_hiz_i (ext_hiz_i),
    .pat_i     (word.pat),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o)
  );

  assign host_rdata_o = rdata;
  assign running_o    = run;
  assign stop_cause_o = cause;
  assign cur_addr_o   = ptr;

  a_r4_rec_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && mode == MODE_REC) |-> !pin_oe_o);
  a_r3_hiz_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word.hiz || ext_hiz_i) |-> !pin_oe_o);
  a_r6_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_err_o |-> (!run && cause == STOP_ERR));
endmodule

// File: tb/sim_pattern_port.sv
module sim_pattern_port;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 0, host_re = 0, host_reg = 0;
  logic [AW-1:0] host_addr = '0;
  logic [11:0] host_wdata = '0, host_rdata;
  logic start = 0, abort = 0, ext = 0;
  logic [7:0] pin = '0, pin_out, f_exp, f_act;
  logic pin_oe, running, cerr;
  logic [1:0] cause;
  logic [AW-1:0] cur_addr, f_addr;

  pattern_port #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .host_we_i(host_we), .host_re_i(host_re), .host_reg_i(host_reg),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .start_i(start), .abort_i(abort), .ext_hiz_i(ext), .pin_i(pin),
    .pin_o(pin_out), .pin_oe_o(pin_oe), .running_o(running), .cmp_err_o(cerr),
    .stop_cause_o(cause), .cur_addr_o(cur_addr), .fail_addr_o(f_addr),
    .fail_exp_o(f_exp), .fail_act_o(f_act)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [11:0] mm [DEPTH];
  int m_mode = 0;
  logic [7:0] m_mask = '0, m_fe = '0, m_fx = '0, force_xor = '0;
  logic [AW-1:0] m_pre = '0, m_brd = '0, m_ptr = '0, m_fa = '0;
  logic m_run = 0, m_err = 0;
  int m_cause = 0, abort_at = -1;
  bit poke = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  task automatic hwr(bit isreg, int a, int d);
    @(negedge clk);
    host_we = 1; host_reg = isreg; host_addr = AW'(a); host_wdata = 12'(d);
    @(negedge clk);
    host_we = 0; host_reg = 0;
  endtask

  task automatic hrd(int a, output logic [11:0] d);
    @(negedge clk);
    host_re = 1; host_addr = AW'(a);
    @(negedge clk);
    host_re = 0;
    #1 d = host_rdata;
  endtask

  task automatic set_cfg(int mode, int mask, int pre, int brd);
    hwr(1, 0, mode); hwr(1, 1, mask); hwr(1, 2, pre); hwr(1, 3, brd);
    m_mode = mode; m_mask = 8'(mask); m_pre = AW'(pre); m_brd = AW'(brd);
  endtask

  task automatic load_prog();
    for (int i = 0; i < DEPTH; i++) hwr(0, i, int'(mm[i]));
  endtask

  function automatic logic [11:0] mkw(bit br, bit eos, bit ce, bit hz, logic [7:0] p);
    return {br, eos, ce, hz, p};
  endfunction

  function automatic string cause_tag(int c);
    case (c)
      1: return "R7 end cause";
      2: return "R6 error cause";
      3: return "R9 abort cause";
      default: return "R2 cause";
    endcase
  endfunction

  task automatic run_seq(int max_cyc);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    m_run = 1; m_ptr = m_pre; m_cause = 0; m_err = 0; m_fa = '0; m_fe = '0; m_fx = '0;
    for (int c = 0; c < max_cyc && m_run; c++) begin
      logic [11:0] w;
      logic [7:0] p;
      logic ab, ex, stim;
      w = mm[m_ptr];
      ex = ($urandom % 5) == 0;
      ab = (c == abort_at) || (c == max_cyc - 1);
      if (force_xor != 0) p = w[7:0] ^ force_xor;
      else if ($urandom % 6 == 0) p = 8'($urandom);
      else p = w[7:0];
      pin = p; ext = ex; abort = ab;
      if (poke && c == 2) begin
        start = 1; host_we = 1; host_reg = 0; host_addr = AW'(5); host_wdata = ~mm[5];
      end
      if (poke && c == 3) begin
        host_we = 1; host_reg = 1; host_addr = AW'(2); host_wdata = 12'(m_pre + 1);
      end
      #1;
      stim = (m_mode == 0);
      chk("R2 running", running, 1);
      chk("R2 R8 address", cur_addr, m_ptr);
      chk("R3 R4 output enable", pin_oe, stim && !w[8] && !ex);
      chk("R3 pin value", pin_out, stim ? w[7:0] : 8'h00);
      chk("R5 no error while running", cerr, 0);
      if (ab) begin
        m_run = 0; m_cause = 3;
      end else if (m_mode == 2 && w[9] && (((p ^ w[7:0]) & ~m_mask) != 0)) begin
        m_run = 0; m_cause = 2; m_err = 1; m_fa = m_ptr; m_fe = w[7:0]; m_fx = p;
      end else begin
        if (m_mode == 1) mm[m_ptr][7:0] = p;
        if (w[10]) begin
          m_run = 0; m_cause = 1;
        end else m_ptr = w[11] ? m_brd : m_ptr + 1'b1;
      end
      @(negedge clk);
      start = 0; abort = 0; host_we = 0; host_reg = 0; ext = 0;
    end
    #1;
    chk("R7 R9 stopped", running, 0);
    chk(cause_tag(m_cause), cause, m_cause);
    chk("R5 error flag", cerr, m_err);
    chk("R6 fail address", f_addr, m_fa);
    chk("R6 fail expected", f_exp, m_fe);
    chk("R6 fail actual", f_act, m_fx);
    chk("R7 stop address", cur_addr, m_ptr);
    chk("R3 no drive when stopped", pin_oe, 0);
  endtask

  task automatic verify_mem(int lo, int hi, string tag);
    logic [11:0] d;
    for (int i = lo; i <= hi; i++) begin
      hrd(i, d);
      chk(tag, d, mm[i]);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 running", running, 0);
    chk("R1 cause", cause, 0);
    chk("R1 error", cerr, 0);
    chk("R1 address", cur_addr, 0);
    chk("R1 output enable", pin_oe, 0);
    chk("R1 pin", pin_out, 0);

    // R1: registers reset to zero -> stimulus mode, start at 0
    clear_prog();
    mm[0] = mkw(0, 0, 0, 0, 8'hA5);
    mm[1] = mkw(0, 0, 0, 1, 8'h3C);
    mm[2] = mkw(0, 0, 0, 0, 8'h0F);
    mm[3] = mkw(0, 1, 0, 0, 8'hF0);
    load_prog();
    run_seq(20);
    verify_mem(0, 3, "R10 host readback");

    // R4 record
    clear_prog();
    for (int i = 0; i < 6; i++) mm[i] = mkw(0, i == 4, 1, 1, 8'(i * 17));
    load_prog();
    set_cfg(1, 0, 0, 0);
    run_seq(20);
    verify_mem(0, 5, "R4 record write");

    // R5 full mask, every pin wrong -> no error
    clear_prog();
    for (int i = 0; i < 4; i++) mm[i] = mkw(0, i == 3, 1, 0, 8'(i + 40));
    load_prog();
    set_cfg(2, 8'hFF, 0, 0);
    force_xor = 8'hFF;
    run_seq(20);

    // R5 disabled word skipped, R6 failure at address 1
    mm[0] = mkw(0, 0, 0, 0, 8'h11);
    mm[1] = mkw(0, 0, 1, 0, 8'h22);
    load_prog();
    set_cfg(2, 8'hF0, 0, 0);
    force_xor = 8'h01;
    run_seq(20);
    chk("R6 captured address", f_addr, 1);

    // R9 abort beats a failure in the same cycle
    abort_at = 1;
    run_seq(20);
    chk("R9 abort over error", cerr, 0);
    abort_at = -1;
    force_xor = 0;

    // R8 branch, end over branch
    clear_prog();
    mm[2] = mkw(1, 0, 0, 0, 8'h77);
    mm[8] = mkw(1, 1, 0, 0, 8'h88);
    load_prog();
    set_cfg(0, 0, 0, 8);
    run_seq(20);
    chk("R8 end over branch", cur_addr, 8);

    // R10 R11 writes and start ignored while running
    clear_prog();
    mm[7] = mkw(1, 0, 0, 0, 8'h07);
    load_prog();
    set_cfg(0, 0, 0, 0);
    poke = 1;
    run_seq(30);
    poke = 0;
    verify_mem(5, 5, "R10 memory write while running");
    run_seq(3);

    // wrap of the address counter
    clear_prog();
    mm[1] = mkw(0, 1, 0, 0, 8'h01);
    load_prog();
    set_cfg(0, 0, DEPTH - 2, 0);
    run_seq(10);
    chk("R2 wrap", cur_addr, 1);

    // random programs
    for (int r = 0; r < 30; r++) begin
      for (int i = 0; i < DEPTH; i++)
        mm[i] = mkw(($urandom % 8) == 0, ($urandom % 16) == 0, ($urandom % 2) == 0,
                    ($urandom % 4) == 0, 8'($urandom));
      load_prog();
      set_cfg(int'($urandom % 3), ($urandom % 2) ? int'($urandom % 256) : 0,
              int'($urandom % DEPTH), int'($urandom % DEPTH));
      run_seq(150);
      if (m_mode == 1) verify_mem(0, DEPTH - 1, "R4 random record");
    end

    summary();
    $finish;
  end
endmodule